// File: doc/BRIEF.md
# Partitioned SIMD Integer ALU

This block is a fixed-point execution unit for a 64-bit operand pair. At run time the operands are read as one 64-bit word or as two, four or eight narrower lanes. Each lane computes on its own, in parallel with the others. The unit adds, subtracts and performs bitwise AND, OR and XOR.

Every accepted operation passes through two register stages. Its result, its destination tag and a valid flag appear at the outputs two clock edges after issue.

Each issued operation carries a tag for each of its two source registers and a tag for its destination. If a source tag names the destination of the operation now in the first stage, that result does not exist yet. In that case the block raises `stall` for one cycle and does not take the operation. The issuer must keep the operation on its inputs until `stall` is low. A source tag that matches the operation in the final stage takes that stage's result in place of the supplied operand, with no stall.

Top module: `simd_alu`

## Requirements
- R1: With `lane_sel` 2'b00 the operands form one 64-bit lane; 2'b01 gives two 32-bit lanes, 2'b10 four 16-bit lanes and 2'b11 eight 8-bit lanes. For ADD (opcode 0) each lane holds the lane sum modulo 2^W. No carry passes from the top bit of one lane into the bottom bit of the next.
- R2: For SUB (opcode 1) each lane holds (a - b) modulo 2^W for lane width W. No borrow crosses a lane boundary.
- R3: AND (opcode 2), OR (opcode 3) and XOR (opcode 4) give the bitwise result over all 64 bits, whatever the value of `lane_sel`.
- R4: An operation accepted at clock edge k appears at edge k+2. At that point `res_valid` is 1, `res_tag` equals its destination tag and `res_data` equals its result.
- R5: When `issue_valid` is 1, the first stage holds a valid operation, and either source tag equals that operation's destination tag, `stall` is 1 and the operation is not accepted. The cycle after a stall has no stall, and the refused cycle produces no result.
- R6: A source tag equal to the tag of the valid result in the final stage takes that stage's `res_data` instead of the supplied operand. This happens without any stall.
- R7: A synchronous active-high `rst` clears both stage valid bits, so `res_valid` is 0 and `stall` is 0 after reset.
- R8: With `issue_valid` at 0, `stall` stays 0 whatever the tags are, and no result appears two cycles later.
- R9: Opcodes 5, 6 and 7 produce an all-zero result that is still delivered with `res_valid` and its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 3 | Operation code |
| lane_sel | input | 2 | Lane size select |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| tag_a | input | 5 | Register tag of the first operand |
| tag_b | input | 5 | Register tag of the second operand |
| tag_d | input | 5 | Destination register tag |
| res_data | output | 64 | Result |
| res_tag | output | 5 | Destination tag of the result |
| res_valid | output | 1 | Result is valid |
| stall | output | 1 | Operation not accepted; hold it |

## Verification
Addition and subtraction are applied at every lane size to operand pairs chosen so that every lane carries or borrows out of its top bit. A single wrong partition boundary therefore shows up in the neighbouring lane. The same operands at different lane sizes give different expected words, which separates the four lane encodings. Logic operations use two distinct bit patterns under two lane sizes; any carry or lane dependence would appear there. Three timing patterns are used: a dependent operation issued one cycle after its producer, one issued two cycles after, and an independent operation back to back. Together they tell apart a correct stall, a correct forward, a stale operand and a dropped or duplicated result.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4
   } alu_op_e;

   typedef enum logic [1:0] {
      LANE_64 = 2'b00,
      LANE_32 = 2'b01,
      LANE_16 = 2'b10,
      LANE_8  = 2'b11
   } lane_e;

   localparam int SLICE_W = 8;
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic [1:0]        lane_sel,
   output logic [DATA_W-1:0] sum
);
   localparam int NSLICE = DATA_W / SLICE_W;

   initial begin
      if (DATA_W % 64 != 0) $error("DATA_W must be a multiple of 64");
   end

   logic [NSLICE-1:0] cut;
   logic [NSLICE:0]   cy;
   logic [3:0]        lane_bytes;

   always_comb begin
      case (lane_sel)
         LANE_64: lane_bytes = 4'd8;
         LANE_32: lane_bytes = 4'd4;
         LANE_16: lane_bytes = 4'd2;
         default: lane_bytes = 4'd1;
      endcase
   end

   genvar i;
   generate
      for (i = 0; i < NSLICE; i++) begin : g_slice
         logic [SLICE_W:0]   part;
         logic [SLICE_W-1:0] bop;
         logic               cin;
         assign cut[i] = ((i[3:0] & (lane_bytes - 4'd1)) == 4'd0);
         assign bop    = sub ? ~b[i*SLICE_W +: SLICE_W] : b[i*SLICE_W +: SLICE_W];
         assign cin    = cut[i] ? sub : cy[i];
         assign part   = {1'b0, a[i*SLICE_W +: SLICE_W]} + {1'b0, bop}
                         + {{SLICE_W{1'b0}}, cin};
         assign sum[i*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
         assign cy[i+1] = part[SLICE_W];
      end
   endgenerate

   assign cy[0] = sub;
endmodule

// File: rtl/simd_hazard.sv
module simd_hazard #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 5
) (
   input  logic              issue_valid,
   input  logic [TAG_W-1:0]  tag_a,
   input  logic [TAG_W-1:0]  tag_b,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic              s1_vld,
   input  logic [TAG_W-1:0]  s1_tag,
   input  logic              s2_vld,
   input  logic [TAG_W-1:0]  s2_tag,
   input  logic [DATA_W-1:0] s2_data,
   output logic              hold,
   output logic [DATA_W-1:0] opa,
   output logic [DATA_W-1:0] opb
);
   logic near_hit;

   assign near_hit = s1_vld && ((tag_a == s1_tag) || (tag_b == s1_tag));
   assign hold     = issue_valid && near_hit;
   assign opa      = (s2_vld && (tag_a == s2_tag)) ? s2_data : src_a;
   assign opb      = (s2_vld && (tag_b == s2_tag)) ? s2_data : src_b;
endmodule

// File: rtl/simd_alu.sv
module simd_alu
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue_valid,
   input  logic [2:0]        opcode,
   input  logic [1:0]        lane_sel,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [TAG_W-1:0]  tag_a,
   input  logic [TAG_W-1:0]  tag_b,
   input  logic [TAG_W-1:0]  tag_d,
   output logic [DATA_W-1:0] res_data,
   output logic [TAG_W-1:0]  res_tag,
   output logic              res_valid,
   output logic              stall
);
   initial begin
      if (TAG_W < 1) $error("TAG_W must be at least 1");
   end

   logic              s1_vld;
   logic [2:0]        s1_op;
   logic [1:0]        s1_lane;
   logic [DATA_W-1:0] s1_a, s1_b;
   logic [TAG_W-1:0]  s1_tag;
   logic [DATA_W-1:0] opa, opb, arith, comb_res;
   logic              hold, accept;

   simd_hazard #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_hazard (
      .issue_valid (issue_valid),
      .tag_a       (tag_a),
      .tag_b       (tag_b),
      .src_a       (src_a),
      .src_b       (src_b),
      .s1_vld      (s1_vld),
      .s1_tag      (s1_tag),
      .s2_vld      (res_valid),
      .s2_tag      (res_tag),
      .s2_data     (res_data),
      .hold        (hold),
      .opa         (opa),
      .opb         (opb)
   );

   assign stall  = hold;
   assign accept = issue_valid && !hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld <= 1'b0;
      end else begin
         s1_vld <= accept;
      end
      if (accept) begin
         s1_op   <= opcode;
         s1_lane <= lane_sel;
         s1_a    <= opa;
         s1_b    <= opb;
         s1_tag  <= tag_d;
      end
   end

   simd_lane_adder #(.DATA_W(DATA_W)) u_add (
      .a        (s1_a),
      .b        (s1_b),
      .sub      (s1_op == OP_SUB),
      .lane_sel (s1_lane),
      .sum      (arith)
   );

   always_comb begin
      case (s1_op)
         OP_ADD, OP_SUB: comb_res = arith;
         OP_AND:         comb_res = s1_a & s1_b;
         OP_OR:          comb_res = s1_a | s1_b;
         OP_XOR:         comb_res = s1_a ^ s1_b;
         default:        comb_res = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
      end else begin
         res_valid <= s1_vld;
      end
      if (s1_vld) begin
         res_data <= comb_res;
         res_tag  <= s1_tag;
      end
   end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              issue_valid,
   input logic [TAG_W-1:0]  tag_d,
   input logic [TAG_W-1:0]  res_tag,
   input logic              res_valid,
   input logic              stall
);
   AST_STALL_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
      stall |-> issue_valid); // R8

   AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      stall |=> !stall); // R5

   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> $past(issue_valid && !stall, 2)); // R4

   AST_RESULT_TAG: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (res_tag == $past(tag_d, 2))); // R4

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!res_valid && !stall)); // R7
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .issue_valid (issue_valid),
   .tag_d       (tag_d),
   .res_tag     (res_tag),
   .res_valid   (res_valid),
   .stall       (stall)
);

// File: tb/tb_simd_alu.sv
module tb_simd_alu;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        issue_valid = 1'b0;
   logic [2:0]  opcode = '0;
   logic [1:0]  lane_sel = '0;
   logic [63:0] src_a = '0, src_b = '0;
   logic [4:0]  tag_a = 5'd2, tag_b = 5'd3, tag_d = 5'd1;
   logic [63:0] res_data;
   logic [4:0]  res_tag;
   logic        res_valid, stall;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   simd_alu dut (
      .clk(clk), .rst(rst), .issue_valid(issue_valid), .opcode(opcode),
      .lane_sel(lane_sel), .src_a(src_a), .src_b(src_b), .tag_a(tag_a),
      .tag_b(tag_b), .tag_d(tag_d), .res_data(res_data), .res_tag(res_tag),
      .res_valid(res_valid), .stall(stall)
   );

   function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] ls,
                                         input logic [63:0] a, input logic [63:0] b);
      int w;
      logic [63:0] m, r, x, y;
      w = 64 >> ls;
      m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      r = '0;
      case (op)
         3'd0, 3'd1: begin
            for (int k = 0; k < 64 / w; k++) begin
               x = (a >> (k * w)) & m;
               y = (b >> (k * w)) & m;
               r |= (((op == 3'd0) ? (x + y) : (x - y)) & m) << (k * w);
            end
         end
         3'd2: r = a & b;
         3'd3: r = a | b;
         3'd4: r = a ^ b;
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [1:0] ls, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] ta, input logic [4:0] tb,
                        input logic [4:0] td);
      issue_valid = 1'b1; opcode = op; lane_sel = ls;
      src_a = a; src_b = b; tag_a = ta; tag_b = tb; tag_d = td;
   endtask

   task automatic idle();
      issue_valid = 1'b0; tag_a = 5'd2; tag_b = 5'd3; tag_d = 5'd1;
   endtask

   task automatic single(input string req, input logic [2:0] op, input logic [1:0] ls,
                         input logic [63:0] a, input logic [63:0] b);
      drive(op, ls, a, b, 5'd2, 5'd3, 5'd1);
      @(negedge clk); idle();
      @(negedge clk);
      chk(req, {63'd0, res_valid}, 64'd1);
      chk(req, res_data, model(op, ls, a, b));
   endtask

   task automatic t_reset();
      chk("R7 valid", {63'd0, res_valid}, 64'd0);
      chk("R7 stall", {63'd0, stall}, 64'd0);
   endtask

   task automatic t_add();
      for (int l = 0; l < 4; l++) begin
         single("R1", 3'd0, l[1:0], 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
         single("R1", 3'd0, l[1:0], 64'h80FF_7FFF_FFFF_8001, 64'h8001_8001_0001_7FFF);
      end
   endtask

   task automatic t_sub();
      for (int l = 0; l < 4; l++) begin
         single("R2", 3'd1, l[1:0], 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
         single("R2", 3'd1, l[1:0], 64'h1234_0000_8000_00FF, 64'h0001_0001_0001_0100);
      end
   endtask

   task automatic t_logic();
      for (int o = 2; o < 5; o++) begin
         single("R3", o[2:0], 2'b11, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_4321_F0F0_00FF);
         single("R3", o[2:0], 2'b00, 64'hAAAA_5555_0F0F_F0F0, 64'hFFFF_0000_3C3C_C3C3);
      end
   endtask

   task automatic t_badop();
      for (int o = 5; o < 8; o++) begin
         drive(o[2:0], 2'b01, 64'hDEAD_BEEF_0000_1111, 64'h1111_2222_3333_4444, 5'd2, 5'd3, 5'd9);
         @(negedge clk); idle();
         @(negedge clk);
         chk("R9 data", res_data, 64'd0);
         chk("R9 tag", {59'd0, res_tag}, 64'd9);
      end
   endtask

   task automatic t_latency();
      logic [63:0] r1, r2;
      r1 = model(3'd0, 2'b10, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040);
      r2 = model(3'd4, 2'b00, 64'h5A5A_5A5A_5A5A_5A5A, 64'hFFFF_0000_FFFF_0000);
      drive(3'd0, 2'b10, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040, 5'd2, 5'd3, 5'd11);
      @(negedge clk);
      drive(3'd4, 2'b00, 64'h5A5A_5A5A_5A5A_5A5A, 64'hFFFF_0000_FFFF_0000, 5'd4, 5'd5, 5'd12);
      #1 chk("R4 no stall indep", {63'd0, stall}, 64'd0);
      chk("R4 not early", {63'd0, res_valid}, 64'd0);
      @(negedge clk); idle();
      chk("R4 first", res_data, r1);
      chk("R4 first tag", {59'd0, res_tag}, 64'd11);
      @(negedge clk);
      chk("R4 second", res_data, r2);
      chk("R4 second tag", {59'd0, res_tag}, 64'd12);
      @(negedge clk);
      chk("R4 drained", {63'd0, res_valid}, 64'd0);
   endtask

   task automatic t_stall();
      logic [63:0] p, q;
      p = model(3'd0, 2'b11, 64'hFF80_7F01_0203_0405, 64'h0180_0101_1010_2020);
      q = model(3'd1, 2'b11, p, 64'h0102_0304_0506_0708);
      drive(3'd0, 2'b11, 64'hFF80_7F01_0203_0405, 64'h0180_0101_1010_2020, 5'd2, 5'd3, 5'd20);
      @(negedge clk);
      drive(3'd1, 2'b11, 64'hBAD0_BAD0_BAD0_BAD0, 64'h0102_0304_0506_0708, 5'd20, 5'd6, 5'd21);
      #1 chk("R5 stall raised", {63'd0, stall}, 64'd1);
      @(negedge clk);
      chk("R5 stall one cycle", {63'd0, stall}, 64'd0);
      chk("R5 producer result", res_data, p);
      @(negedge clk); idle();
      chk("R5 refused cycle empty", {63'd0, res_valid}, 64'd0);
      @(negedge clk);
      chk("R5 dependent result", res_data, q);
      chk("R5 dependent tag", {59'd0, res_tag}, 64'd21);
   endtask

   task automatic t_forward();
      logic [63:0] p, q;
      p = model(3'd3, 2'b00, 64'h0000_FFFF_0000_1234, 64'h00F0_0000_0F00_0000);
      q = model(3'd0, 2'b01, 64'h0000_0001_FFFF_FFFF, p);
      drive(3'd3, 2'b00, 64'h0000_FFFF_0000_1234, 64'h00F0_0000_0F00_0000, 5'd2, 5'd3, 5'd25);
      @(negedge clk); idle();
      @(negedge clk);
      drive(3'd0, 2'b01, 64'h0000_0001_FFFF_FFFF, 64'hBAD1_BAD1_BAD1_BAD1, 5'd7, 5'd25, 5'd26);
      #1 chk("R6 no stall", {63'd0, stall}, 64'd0);
      @(negedge clk); idle();
      @(negedge clk);
      chk("R6 forwarded", res_data, q);
   endtask

   task automatic t_noissue();
      drive(3'd0, 2'b00, 64'd5, 64'd6, 5'd2, 5'd3, 5'd30);
      @(negedge clk);
      issue_valid = 1'b0; tag_a = 5'd30; tag_b = 5'd30;
      #1 chk("R8 no stall when idle", {63'd0, stall}, 64'd0);
      @(negedge clk); idle();
      chk("R8 producer", res_data, 64'd11);
      @(negedge clk);
      chk("R8 no result", {63'd0, res_valid}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_badop();
      t_latency();
      t_stall();
      t_forward();
      t_noissue();
      drive(3'd0, 2'b00, 64'd1, 64'd1, 5'd2, 5'd3, 5'd1);
      @(negedge clk); idle(); rst = 1'b1;
      @(negedge clk);
      chk("R7 reset flush", {63'd0, res_valid}, 64'd0);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule